// File: doc/BRIEF.md
# Microcode ALU with Optional Carry Update

This block is the arithmetic and logic unit of a small 16-bit microcode engine. Each operation carries an operation code, two operands and a flag that asks for the carry to be updated. The block returns a 16-bit result in the same cycle. It also holds one carry flag. That flag feeds the carry-in forms of add and subtract, and it changes only when the caller sets the update flag on an add or subtract.

Operations travel as a stream. An operation is offered with `in_valid`, and its result is presented with `out_valid` in the same cycle. A transfer happens in any cycle where `in_valid` and `out_ready` are both high. The consumer applies back-pressure by lowering `out_ready`. That lowers `in_ready` combinationally, and the producer must then hold the operation stable. The stored carry commits only on a transfer, so a stalled operation can be offered again and again without changing the flag twice.

The result logic has no state. The only register is the carry flag. A register copy is done with the OR code and a zero second operand.

Top module: `ucode_alu`

## Requirements
- R1: Op code 0 gives a+b and op code 1 gives a+b+C, both modulo 2^16, where C is the stored carry.
- R2: Op code 2 gives a-b and op code 3 gives a-b-(1-C), both modulo 2^16.
- R3: On a transfer of op codes 0 to 3 with `upd_carry`=1, the stored carry takes the carry-out of the 17-bit sum. For subtraction this means 1 when no borrow occurred.
- R4: With `upd_carry`=0, or with any op code outside 0 to 3, the stored carry keeps its value.
- R5: Op code 4 is an arithmetic right shift (sign fill), 5 a logical right shift and 6 a left shift. The amount is b[3:0], and b[15:4] has no effect.
- R6: Op code 7 rotates a left and op code 8 rotates a right, by b[3:0].
- R7: Op codes 9, 10 and 11 give a|b, a&b and a^b. OR with b=0 returns a unchanged.
- R8: Op code 12 clears bits: a & ~b.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The carry changes only in a cycle where `in_valid` and `out_ready` are both 1.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears the carry to 0.
- R11: Op codes 13 to 15 give a zero result and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle |
| alu_op | input | 4 | Operation code |
| upd_carry | input | 1 | Request carry update (add/subtract only) |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand / shift amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| result | output | 16 | Operation result |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The carry flag is the only state. A wrong value in it first appears at the ports on `carry_flag` in the cycle after the bad commit. It shows again in the result of the next carry-in add or subtract, because that result is off by one. A flag that is written without a transfer, or by a plain form, shows one cycle later on `carry_flag`. The bench therefore checks the flag after every table entry, and it runs stalled and idle cycles that would expose a stray write.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_SRA  = 4'd4,
    OP_SRL  = 4'd5,
    OP_SLL  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_OR   = 4'd9,
    OP_AND  = 4'd10,
    OP_XOR  = 4'd11,
    OP_CLR  = 4'd12,
    OP_RS13 = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } op_e;
endpackage

// File: rtl/ucode_alu_addsub.sv
module ucode_alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         neg_y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  // subtraction reuses the adder: a + ~b + cin
  assign y_eff = neg_y ? ~y : y;
  assign wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
endmodule

// File: rtl/ucode_alu_shift.sv
module ucode_alu_shift
  import ucode_alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  op_e            op,
  input  logic [W-1:0]   x,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   res
);
  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [W-1:0]   sra_v;

  assign dbl   = {x, x};
  assign dbl_l = dbl << amt;
  assign dbl_r = dbl >> amt;
  assign sra_v = $unsigned($signed(x) >>> amt);

  always_comb begin
    unique case (op)
      OP_SRA:  res = sra_v;
      OP_SRL:  res = x >> amt;
      OP_SLL:  res = x << amt;
      OP_ROL:  res = dbl_l[2*W-1:W];
      OP_ROR:  res = dbl_r[W-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ucode_alu_logic.sv
module ucode_alu_logic
  import ucode_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_OR:   res = x | y;
      OP_AND:  res = x & y;
      OP_XOR:  res = x ^ y;
      OP_CLR:  res = x & ~y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu
  import ucode_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   alu_op,
  input  logic         upd_carry,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         carry_flag
);
  localparam int SHW = $clog2(W);

  op_e          op_c;
  logic         xfer;
  logic         is_arith;
  logic         is_sub;
  logic         use_cin;
  logic         as_cin;
  logic         as_cout;
  logic [W-1:0] as_res;
  logic [W-1:0] sh_res;
  logic [W-1:0] lg_res;
  logic         carry_q;

  assign op_c      = op_e'(alu_op);
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign xfer      = in_valid & out_ready;

  assign is_arith = (op_c == OP_ADD) || (op_c == OP_ADDC) ||
                    (op_c == OP_SUB) || (op_c == OP_SUBC);
  assign is_sub   = (op_c == OP_SUB) || (op_c == OP_SUBC);
  assign use_cin  = (op_c == OP_ADDC) || (op_c == OP_SUBC);
  // plain add: cin 0; plain sub: cin 1; carry-in forms: stored flag
  assign as_cin   = use_cin ? carry_q : is_sub;

  ucode_alu_addsub #(.W(W)) u_addsub (
    .x    (opnd_a),
    .y    (opnd_b),
    .neg_y(is_sub),
    .cin  (as_cin),
    .sum  (as_res),
    .cout (as_cout)
  );

  ucode_alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .op (op_c),
    .x  (opnd_a),
    .amt(opnd_b[SHW-1:0]),
    .res(sh_res)
  );

  ucode_alu_logic #(.W(W)) u_logic (
    .op (op_c),
    .x  (opnd_a),
    .y  (opnd_b),
    .res(lg_res)
  );

  always_comb begin
    unique case (op_c)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC:        result = as_res;
      OP_SRA, OP_SRL, OP_SLL, OP_ROL, OP_ROR:  result = sh_res;
      OP_OR, OP_AND, OP_XOR, OP_CLR:           result = lg_res;
      default:                                 result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      carry_q <= 1'b0;
    else if (xfer && upd_carry && is_arith)
      carry_q <= as_cout;
  end

  assign carry_flag = carry_q;
endmodule

// File: rtl/ucode_alu_chk.sv
module ucode_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   alu_op,
  input logic         upd_carry,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic         carry_flag
);
  logic         xfer;
  logic         arith;
  logic [W:0]   add_wide;

  assign xfer     = in_valid && out_ready;
  assign arith    = alu_op < 4'd4;
  assign add_wide = {1'b0, opnd_a} + {1'b0, opnd_b};

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !carry_flag);

  a_r9_no_xfer_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(carry_flag));

  a_r4_plain_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer && !(upd_carry && arith)) |=> $stable(carry_flag));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
    (xfer && upd_carry && alu_op == 4'd0) |=> carry_flag == $past(add_wide[W]));

  a_r9_valid_ready: assert property (@(posedge clk) disable iff (rst)
    (out_valid == in_valid) && (in_ready == out_ready));

  a_r7_or_copy: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 4'd9 && opnd_b == '0) |-> result == opnd_a);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (alu_op > 4'd12) |-> result == '0);
endmodule

bind ucode_alu ucode_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .alu_op    (alu_op),
  .upd_carry (upd_carry),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .carry_flag(carry_flag)
);

// File: tb/test_ucode_alu.sv
module test_ucode_alu;
  localparam int W  = 16;
  localparam int NV = 21;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [3:0]   alu_op;
  logic         upd_carry;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] result;
  logic         carry_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ucode_alu #(.W(W)) i_ucode_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .alu_op(alu_op), .upd_carry(upd_carry), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .carry_flag(carry_flag)
  );

  // {op, upd, a, b, expected result, expected carry afterwards}
  localparam logic [53:0] TV [NV] = '{
    {4'd0,  1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},  // R1 R3 add, carry out
    {4'd1,  1'b0, 16'h0001, 16'h0001, 16'h0003, 1'b1},  // R1 R4 addc uses C=1
    {4'd2,  1'b0, 16'h0005, 16'h0007, 16'hFFFE, 1'b1},  // R2 R4 plain sub keeps C
    {4'd2,  1'b1, 16'h0005, 16'h0007, 16'hFFFE, 1'b0},  // R3 borrow -> 0
    {4'd3,  1'b0, 16'h0010, 16'h0001, 16'h000E, 1'b0},  // R2 subc with C=0
    {4'd1,  1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b1},  // R3 addc carry out
    {4'd3,  1'b1, 16'h0010, 16'h0001, 16'h000F, 1'b1},  // R2 R3 subc C=1 no borrow
    {4'd0,  1'b0, 16'h1234, 16'h1111, 16'h2345, 1'b1},  // R1
    {4'd4,  1'b0, 16'h8000, 16'h0004, 16'hF800, 1'b1},  // R5 sign fill
    {4'd5,  1'b0, 16'h8000, 16'h0014, 16'h0800, 1'b1},  // R5 b[15:4] ignored
    {4'd6,  1'b0, 16'h0003, 16'h000F, 16'h8000, 1'b1},  // R5 left by 15
    {4'd7,  1'b0, 16'h8001, 16'h0001, 16'h0003, 1'b1},  // R6 rotate left
    {4'd8,  1'b0, 16'h8001, 16'h0004, 16'h1800, 1'b1},  // R6 rotate right
    {4'd9,  1'b0, 16'h1234, 16'h0000, 16'h1234, 1'b1},  // R7 copy via OR
    {4'd10, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b1},  // R7 and
    {4'd11, 1'b0, 16'hF0F0, 16'h3C3C, 16'hCCCC, 1'b1},  // R7 xor
    {4'd12, 1'b0, 16'hF0F0, 16'h3C3C, 16'hC0C0, 1'b1},  // R8 clear bits
    {4'd13, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1},  // R11 unused code
    {4'd4,  1'b1, 16'h0001, 16'h0001, 16'h0000, 1'b1},  // R4 shift ignores upd
    {4'd2,  1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b0},  // R2 R3 0-1 borrow
    {4'd0,  1'b1, 16'h0001, 16'h0002, 16'h0003, 1'b0}   // R3 no carry out
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one transfer of one operation; result checked combinationally, carry after the edge
  task automatic run_op(string req, logic [3:0] op, logic upd,
                        logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] exp_res, logic exp_c);
    @(negedge clk);
    alu_op = op; upd_carry = upd; opnd_a = a; opnd_b = b;
    in_valid = 1'b1; out_ready = 1'b1;
    #1 check(req, result, exp_res);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(req, {{(W-1){1'b0}}, carry_flag}, {{(W-1){1'b0}}, exp_c});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; alu_op = 4'd0;
    upd_carry = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R10 reset carry", {{(W-1){1'b0}}, carry_flag}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = TV[i];
      run_op($sformatf("table entry %0d", i), v[53:50], v[49], v[48:33],
             v[32:17], v[16:1], v[0]);
    end

    // R9: stalled consumer, carry stays 0, handshake pins follow
    @(negedge clk);
    alu_op = 4'd0; upd_carry = 1'b1; opnd_a = 16'hFFFF; opnd_b = 16'h0001;
    in_valid = 1'b1; out_ready = 1'b0;
    #1 check("R9 in_ready low", {{(W-1){1'b0}}, in_ready}, '0);
    check("R9 out_valid high", {{(W-1){1'b0}}, out_valid}, 16'h0001);
    @(posedge clk);
    @(negedge clk);
    check("R9 stall keeps carry", {{(W-1){1'b0}}, carry_flag}, '0);
    // R9: idle producer
    in_valid = 1'b0; out_ready = 1'b1;
    #1 check("R9 out_valid low", {{(W-1){1'b0}}, out_valid}, '0);
    @(posedge clk);
    @(negedge clk);
    check("R9 idle keeps carry", {{(W-1){1'b0}}, carry_flag}, '0);

    run_op("R3 add after stall", 4'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1);
    run_op("R1 addc C=1", 4'd1, 1'b0, 16'h7FFF, 16'h0000, 16'h8000, 1'b1);

    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R10 reset clears carry", {{(W-1){1'b0}}, carry_flag}, '0);
    run_op("R2 subc C=0 after reset", 4'd3, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 1'b0);

    summary();
  end
endmodule